// File: doc/BRIEF.md
# Framed Word Encoder and Serializer

This block turns a stream of 16-bit parallel words into a DC-balanced serial bit stream. Each word period the user presents a payload together with a control qualifier, a data qualifier and an optional flag bit, and latches them with a word strobe. On every bit-clock enable the block sends one bit. When one frame has gone out completely, it builds the next 20-bit frame from the latched word and starts sending it. The frame is a 4-bit coding field that states the word type, followed by a 16-bit word field.

The control qualifier takes priority. A control word carries only the low 14 payload bits. A data word carries all 16 payload bits. When neither qualifier is set, a fixed balanced idle frame goes out instead, so the line never falls silent. A flag-enable input lets the flag act as a seventeenth data bit by choosing between two data codings. A signed running disparity is kept across frames. When a frame would push the line further in the direction it already leans, the whole frame is inverted before it is sent. The bit-clock enable is expected to pulse 20 times per word period, so the serial stream runs back to back with no gaps between frames.

Top module: `framed_word_serializer`

## Requirements
- R1: When the latched control qualifier is 1, the frame before inversion is coding field 4'b0011 in bits [19:16], bits [15:14] zero and payload[13:0] in bits [13:0]. This holds whatever the data qualifier is.
- R2: When the control qualifier is 0 and the data qualifier is 1, the frame before inversion is the coding field in bits [19:16] with the full payload in bits [15:0]. The coding field is 4'b1011 when the effective flag is 1 and 4'b1101 when it is 0.
- R3: When both qualifiers are 0, the frame before inversion is the idle frame 20'h3FF00 (coding 4'b0011, word field 16'hFF00).
- R4: The effective flag equals flag_in only while flag_en is 1. With flag_en at 0 the flag never changes the frame.
- R5: Frames leave on ser_out most significant bit first, one bit per cycle with bit_en high. ser_out does not change in a cycle with bit_en low.
- R6: Exactly 20 bit_en pulses send one frame. The next frame is loaded on the bit_en pulse that follows the 20th bit, with no idle gap.
- R7: Frame disparity is 2·(number of ones) − 20. The frame is inverted in full, coding field included, when its disparity and the running disparity are both strictly positive or both strictly negative. Otherwise it is sent unchanged.
- R8: After each load the running disparity grows by the disparity of the frame actually sent. Its magnitude never exceeds 20.
- R9: Synchronous reset clears the running disparity, forces ser_out low until the first load and leaves an idle word latched, so the first frame after reset is the idle frame.
- R10: Inputs are latched only in a cycle with word_stb high. Input changes without a strobe, and a strobe during a frame that is already being sent, leave the frame in flight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | Latches the word inputs |
| ctl_in | input | 1 | Control-word qualifier |
| dat_in | input | 1 | Data-word qualifier |
| flag_in | input | 1 | Extra flag data bit |
| flag_en | input | 1 | Enables flag as data |
| payload | input | 16 | Parallel word |
| bit_en | input | 1 | Bit-clock enable, one serial bit per pulse |
| ser_out | output | 1 | Serial line output |

## Verification
The checker assumes that a word strobe only matters at the moment a frame is loaded. It also assumes that bit_en is the only thing that advances the shifter, so every property is tied to the load cycle or to the bit count and not to the strobe timing. The stimulus strobes each word before its first bit_en pulse. One deliberate case strobes a different word in the middle of a frame, to show that the frame in flight is not disturbed. The bench sends every combination of qualifiers, flag and flag enable across payloads that drive the running disparity both positive and negative. Some frames use gapped enables and some use continuous enables, so both the hold behaviour and the back-to-back loading are exercised.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int PAYLOAD_W     = 16;
  localparam int CODE_W        = 4;
  localparam int CTL_PAYLOAD_W = 14;
  localparam int FRAME_W       = CODE_W + PAYLOAD_W;

  localparam logic [CODE_W-1:0]    CODE_DATA_F0 = 4'b1101;
  localparam logic [CODE_W-1:0]    CODE_DATA_F1 = 4'b1011;
  localparam logic [CODE_W-1:0]    CODE_CTRL    = 4'b0011;
  localparam logic [CODE_W-1:0]    CODE_IDLE    = 4'b0011;
  localparam logic [PAYLOAD_W-1:0] IDLE_WORD    = 16'hFF00;

  typedef struct packed {
    logic                 ctl;
    logic                 dat;
    logic                 flag;
    logic                 flag_en;
    logic [PAYLOAD_W-1:0] payload;
  } word_req_t;
endpackage

// File: rtl/fws_capture.sv
module fws_capture
  import fws_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stb,
  input  word_req_t req_in,
  output word_req_t req_q
);
  // reset value has both qualifiers low: an idle word is latched
  always_ff @(posedge clk) begin
    if (rst)      req_q <= '0;
    else if (stb) req_q <= req_in;
  end
endmodule

// File: rtl/fws_encoder.sv
module fws_encoder
  import fws_pkg::*;
#(
  parameter int FLAG_SUPPORT = 1
)(
  input  word_req_t          req,
  output logic [FRAME_W-1:0] frame
);
  localparam int PAD_W = PAYLOAD_W - CTL_PAYLOAD_W;

  logic flag_eff;

  generate
    if (FLAG_SUPPORT != 0) begin : g_flag
      assign flag_eff = req.flag & req.flag_en;
    end else begin : g_noflag
      logic unused_flag;
      assign unused_flag = req.flag ^ req.flag_en;
      assign flag_eff    = 1'b0;
    end
  endgenerate

  logic [CODE_W-1:0]    code;
  logic [PAYLOAD_W-1:0] word;

  always_comb begin
    if (req.ctl) begin
      code = CODE_CTRL;
      word = {{PAD_W{1'b0}}, req.payload[CTL_PAYLOAD_W-1:0]};
    end else if (req.dat) begin
      code = flag_eff ? CODE_DATA_F1 : CODE_DATA_F0;
      word = req.payload;
    end else begin
      code = CODE_IDLE;
      word = IDLE_WORD;
    end
  end

  assign frame = {code, word};
endmodule

// File: rtl/fws_disparity.sv
module fws_disparity
  import fws_pkg::*;
#(
  parameter int RD_W = 7
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [FRAME_W-1:0]     frame_raw,
  output logic [FRAME_W-1:0]     frame_tx,
  output logic signed [RD_W-1:0] rd
);
  int                    ones_i;
  logic signed [RD_W-1:0] fd;
  logic signed [RD_W-1:0] sent_d;
  logic                   invert;

  always_comb begin
    ones_i = 0;
    for (int k = 0; k < FRAME_W; k++) ones_i += int'(frame_raw[k]);
    fd     = RD_W'(2 * ones_i - FRAME_W);
    invert = ((rd > 0) && (fd > 0)) || ((rd < 0) && (fd < 0));
    frame_tx = invert ? ~frame_raw : frame_raw;
    sent_d   = invert ? -fd : fd;
  end

  always_ff @(posedge clk) begin
    if (rst)       rd <= '0;
    else if (load) rd <= rd + sent_d;
  end
endmodule

// File: rtl/fws_shifter.sv
module fws_shifter #(
  parameter int FRAME_W = 20,
  parameter int CNT_W   = $clog2(FRAME_W)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic [FRAME_W-1:0] frame_tx,
  output logic               load,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               ser_out
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg;

  assign load = bit_en && (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= LAST;
      sreg    <= '0;
      ser_out <= 1'b0;
    end else if (bit_en) begin
      if (bit_cnt == LAST) begin
        ser_out <= frame_tx[FRAME_W-1];
        sreg    <= {frame_tx[FRAME_W-2:0], 1'b0};
        bit_cnt <= '0;
      end else begin
        ser_out <= sreg[FRAME_W-1];
        sreg    <= {sreg[FRAME_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/framed_word_serializer.sv
module framed_word_serializer
  import fws_pkg::*;
#(
  parameter int FLAG_SUPPORT = 1,
  parameter int RD_W         = 7
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_stb,
  input  logic                 ctl_in,
  input  logic                 dat_in,
  input  logic                 flag_in,
  input  logic                 flag_en,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic                 bit_en,
  output logic                 ser_out
);
  localparam int CNT_W = $clog2(FRAME_W);

  word_req_t              req_in;
  word_req_t              h_req;
  logic [FRAME_W-1:0]     raw_frame;
  logic [FRAME_W-1:0]     tx_frame;
  logic                   load;
  logic [CNT_W-1:0]       bit_cnt;
  logic signed [RD_W-1:0] rd;

  assign req_in = '{ctl: ctl_in, dat: dat_in, flag: flag_in,
                    flag_en: flag_en, payload: payload};

  fws_capture i_capture (
    .clk(clk), .rst(rst), .stb(word_stb), .req_in(req_in), .req_q(h_req)
  );

  fws_encoder #(.FLAG_SUPPORT(FLAG_SUPPORT)) i_encoder (
    .req(h_req), .frame(raw_frame)
  );

  fws_disparity #(.RD_W(RD_W)) i_disparity (
    .clk(clk), .rst(rst), .load(load),
    .frame_raw(raw_frame), .frame_tx(tx_frame), .rd(rd)
  );

  fws_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_shifter (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_tx(tx_frame),
    .load(load), .bit_cnt(bit_cnt), .ser_out(ser_out)
  );
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int FRAME_W = 20,
  parameter int CNT_W   = 5,
  parameter int RD_W    = 7
)(
  input logic                   clk,
  input logic                   rst,
  input logic                   bit_en,
  input logic                   ser_out,
  input logic                   load,
  input logic [CNT_W-1:0]       bit_cnt,
  input logic signed [RD_W-1:0] rd,
  input logic [FRAME_W-1:0]     tx_frame,
  input logic                   hold_ctl,
  input logic                   hold_dat
);
  logic [3:0] tx_code;
  int         tx_disp;
  assign tx_code = tx_frame[FRAME_W-1 -: 4];
  always_comb tx_disp = 2 * $countones(tx_frame) - FRAME_W;

  AST_CTRL_CODE: assert property (@(posedge clk) disable iff (rst)
    load && hold_ctl |-> (tx_code == 4'b0011 || tx_code == 4'b1100)); // R1
  AST_DATA_CODE: assert property (@(posedge clk) disable iff (rst)
    load && !hold_ctl && hold_dat |-> (tx_code == 4'b1101 || tx_code == 4'b0010 ||
                                       tx_code == 4'b1011 || tx_code == 4'b0100)); // R2
  AST_IDLE_FRAME: assert property (@(posedge clk) disable iff (rst)
    load && !hold_ctl && !hold_dat |-> tx_frame == 20'h3FF00); // R3
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser_out)); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(bit_cnt) < FRAME_W); // R6
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> bit_cnt == '0); // R6
  AST_POS_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    load && (rd > 0) |-> tx_disp <= 0); // R7
  AST_NEG_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    load && (rd < 0) |-> tx_disp >= 0); // R7
  AST_RD_UPDATE: assert property (@(posedge clk) disable iff (rst)
    load |=> int'(rd) == int'($past(rd)) + 2 * $countones($past(tx_frame)) - FRAME_W); // R8
  AST_RD_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(rd) <= FRAME_W && int'(rd) >= -FRAME_W); // R8
endmodule

bind framed_word_serializer fws_checker #(
  .FRAME_W(fws_pkg::FRAME_W), .CNT_W(CNT_W), .RD_W(RD_W)
) i_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .ser_out(ser_out), .load(load),
  .bit_cnt(bit_cnt), .rd(rd), .tx_frame(tx_frame),
  .hold_ctl(h_req.ctl), .hold_dat(h_req.dat)
);

// File: tb/test_framed_word_serializer.sv
module test_framed_word_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_stb = 1'b0;
  logic        ctl_in = 1'b0, dat_in = 1'b0, flag_in = 1'b0, flag_en = 1'b0;
  logic [15:0] payload = 16'h0;
  logic        bit_en = 1'b0;
  logic        ser_out;

  int checks = 0;
  int failures = 0;
  int rd_m = 0;

  always #10 clk = ~clk;

  framed_word_serializer i_framed_word_serializer (
    .clk(clk), .rst(rst), .word_stb(word_stb), .ctl_in(ctl_in), .dat_in(dat_in),
    .flag_in(flag_in), .flag_en(flag_en), .payload(payload),
    .bit_en(bit_en), .ser_out(ser_out)
  );

  function automatic logic [19:0] enc(input logic c, input logic d, input logic fl,
                                      input logic fe, input logic [15:0] p);
    if (c)      return {4'b0011, 2'b00, p[13:0]};
    else if (d) return {(fe && fl) ? 4'b1011 : 4'b1101, p};
    else        return 20'h3FF00;
  endfunction

  function automatic logic [19:0] next_expected(input logic [19:0] raw);
    int  fd;
    bit  inv;
    fd  = 2 * $countones(raw) - 20;
    inv = (rd_m > 0 && fd > 0) || (rd_m < 0 && fd < 0);
    rd_m = rd_m + (inv ? -fd : fd);
    return inv ? ~raw : raw;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic c, input logic d, input logic fl,
                        input logic fe, input logic [15:0] p);
    ctl_in = c; dat_in = d; flag_in = fl; flag_en = fe; payload = p;
    word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
  endtask

  // Sends one frame; gapped mode checks hold during idle cycles, and can strobe
  // a different word during the gap after bit stb_at (R10).
  task automatic shift_frame(input bit cont, input int stb_at, output logic [19:0] got,
                             output bit hold_bad);
    got = '0;
    hold_bad = 0;
    for (int i = 0; i < 20; i++) begin
      bit_en = 1'b1;
      @(negedge clk);
      got = {got[18:0], ser_out};
      if (!cont) begin
        bit_en = 1'b0;
        if (i == stb_at) begin
          ctl_in = 1'b1; dat_in = 1'b0; payload = 16'hFFFF; word_stb = 1'b1;
        end
        @(negedge clk);
        word_stb = 1'b0;
        if (ser_out !== got[0]) hold_bad = 1;
      end
    end
    bit_en = 1'b0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [19:0] got, exp;
    bit hb;
    logic [15:0] pats [5] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234, 16'hC001};
    string tag;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 ser_out low after reset", ser_out, 0);
    repeat (4) @(negedge clk);
    check("R9 ser_out low before first load", ser_out, 0);

    // first frame after reset is idle
    shift_frame(0, -1, got, hb);
    exp = next_expected(20'h3FF00);
    check("R9/R3 first frame idle", got, exp);
    check("R5 hold while bit_en low", hb, 0);

    // sweep of qualifiers, flag options and payloads
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 2; d++)
        for (int fe = 0; fe < 2; fe++)
          for (int fl = 0; fl < 2; fl++)
            for (int k = 0; k < 5; k++) begin
              strobe(c[0], d[0], fl[0], fe[0], pats[k]);
              shift_frame(k[0], -1, got, hb);
              exp = next_expected(enc(c[0], d[0], fl[0], fe[0], pats[k]));
              if (c == 1)      tag = "R1/R7/R8 control frame";
              else if (d == 1) tag = (fe == 0 && fl == 1) ? "R4/R2/R7 flag ignored"
                                                         : "R2/R4/R7 data frame";
              else             tag = "R3 idle frame";
              check(tag, got, exp);
              if (k[0] == 0) check("R5 hold while bit_en low", hb, 0);
            end

    // continuous enables: frames back to back
    strobe(0, 1, 0, 0, 16'h0000);
    shift_frame(1, -1, got, hb);
    exp = next_expected(enc(0, 1, 0, 0, 16'h0000));
    check("R6 back-to-back frame 1", got, exp);
    shift_frame(1, -1, got, hb);
    exp = next_expected(enc(0, 1, 0, 0, 16'h0000));
    check("R6/R7 back-to-back frame 2 same word", got, exp);

    // input change without strobe is ignored
    strobe(0, 1, 1, 1, 16'h1234);
    ctl_in = 1'b1; payload = 16'hFFFF; dat_in = 1'b0;
    shift_frame(0, -1, got, hb);
    exp = next_expected(enc(0, 1, 1, 1, 16'h1234));
    check("R10 unstrobed inputs ignored", got, exp);

    // strobe mid-frame: frame in flight unchanged, next frame uses new word
    strobe(0, 1, 0, 0, 16'h00F0);
    shift_frame(0, 9, got, hb);
    exp = next_expected(enc(0, 1, 0, 0, 16'h00F0));
    check("R10 mid-frame strobe leaves frame", got, exp);
    shift_frame(0, -1, got, hb);
    exp = next_expected(enc(1, 0, 0, 0, 16'hFFFF));
    check("R10/R1 mid-frame strobed word sent next", got, exp);

    // reset in the middle: disparity cleared, idle latched
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_m = 0;
    check("R9 ser_out low after second reset", ser_out, 0);
    shift_frame(0, -1, got, hb);
    exp = next_expected(20'h3FF00);
    check("R9 idle after second reset", got, exp);
    strobe(0, 1, 0, 0, 16'h0000);
    shift_frame(0, -1, got, hb);
    check("R8 zero disparity after reset, no inversion", got, {4'b1101, 16'h0000});
    exp = next_expected(enc(0, 1, 0, 0, 16'h0000));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule